// File: doc/BRIEF.md
# Block-Copy Delayed Write-Back Stage

This stage sits at the output of a 2D block-copy engine. Each slot, a DMA sequencer issues one command. On a write command the stage takes the word the datapath has just computed and places it in a one-entry holding register, together with the current destination address. It does not store the word until the next write slot. The flush command empties the holding register at the end of an operation. The held value is therefore always one write slot behind the datapath, and memory sees each word one write phase late.

The stage owns the destination pointer. It moves the pointer one word per captured word, upward or downward. At the end of every row it adds the row modulo, scaled by the channel enable and the direction. It counts rows down from the programmed height and tells the sequencer when the last row has finished. The flush ends the operation, zeroes the remaining row count and raises a one-cycle completion interrupt. Every address sent to memory is folded into the RAM size with an address mask.

Top module: `blit_wb_stage`

## Requirements
- R1: While reset is held and after it is released, `mem_we`, `done_irq`, `seq_complete` and `busy` are 0 and `rows_left` is 0.
- R2: `start` loads the pointer, width, height and direction settings, sets `busy`, and empties the holding register. The first write command after `start` produces no memory write.
- R3: A write command (`slot_cmd` = 1) while the holding register is full stores the held word at the held address. In the same slot it captures the new word and the current pointer, so `mem_we` is high in the cycle after the slot.
- R4: Each captured word moves the pointer by +1 when `cfg_desc` = 0 and by -1 when `cfg_desc` = 1.
- R5: The write that completes a row (the `cfg_width`-th capture of the row) also adds `cfg_modulo` to the pointer, negated when descending. When `cfg_dst_en` = 0 this adjustment is zero.
- R6: `rows_left` starts at `cfg_height` and drops by one at each row end. `seq_complete` pulses for one cycle at the row end that takes it to zero.
- R7: A flush command (`slot_cmd` = 2) stores the held word only when the holding register is full. When the register is empty, the flush issues no write.
- R8: A flush ends the operation. `busy` clears, `rows_left` becomes 0 and `done_irq` is high for exactly one cycle.
- R9: A none command (`slot_cmd` = 0) or a source-read command (`slot_cmd` = 3) changes neither the pointer nor the holding register, and issues no write.
- R10: `mem_addr` is the held address ANDed with a mask of the low `RAM_AW` bits.
- R11: Each slot issues at most one write. Back-to-back write slots give one `mem_we` cycle per stored word.
- R12: Slot commands received while `busy` is 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation, loading the cfg_* values |
| cfg_base | input | PW | Initial destination pointer |
| cfg_modulo | input | PW | Row-end pointer adjustment |
| cfg_desc | input | 1 | 1 = pointer steps downward |
| cfg_dst_en | input | 1 | Destination channel enable, scales the modulo |
| cfg_width | input | CW | Words per row (at least 1) |
| cfg_height | input | HW | Rows in the operation |
| slot_cmd | input | 2 | 0 none, 1 write, 2 flush, 3 source read |
| out_word | input | DW | Word from the datapath, used on write slots |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | PW | Masked write address |
| mem_wdata | output | DW | Write data |
| seq_complete | output | 1 | Last row finished, pulse to the sequencer |
| done_irq | output | 1 | Completion interrupt pulse |
| busy | output | 1 | Operation in progress |
| rows_left | output | HW | Rows still to be finished |

## Verification
The bench targets the first write after a start. A design that stored it immediately would put a spurious word at the base address and shift every later word by one slot. It flushes both a full and an empty holding register. A design that ignored the phase would either lose the last word or write stale data after a flush that follows a start with no writes. Row ends are tested in both directions and with the channel disabled. A wrong sign or a missing enable shows up as a wrong address on the first word of the next row. None and read slots, and commands sent while idle, are placed between writes, so any pointer drift or stray strobe appears in the compared address stream.

// File: rtl/blit_wb_stage.sv
module blit_wb_stage #(
  parameter int PW     = 24,
  parameter int RAM_AW = 16,
  parameter int CW     = 8,
  parameter int HW     = 10,
  parameter int DW     = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [PW-1:0] cfg_base,
  input  logic [PW-1:0] cfg_modulo,
  input  logic          cfg_desc,
  input  logic          cfg_dst_en,
  input  logic [CW-1:0] cfg_width,
  input  logic [HW-1:0] cfg_height,
  input  logic [1:0]    slot_cmd,
  input  logic [DW-1:0] out_word,
  output logic          mem_we,
  output logic [PW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          seq_complete,
  output logic          done_irq,
  output logic          busy,
  output logic [HW-1:0] rows_left
);
  localparam logic [1:0]    CMD_WRITE = 2'd1;
  localparam logic [1:0]    CMD_FLUSH = 2'd2;
  localparam logic [PW-1:0] RAM_MASK  = PW'((65'd1 << RAM_AW) - 65'd1);

  logic          phase_full;
  logic [PW-1:0] ptr, held_addr, row_adj;
  logic [DW-1:0] held_word;
  logic [CW-1:0] col, width_q;
  logic          desc_q;

  wire           act      = busy && !start;
  wire           do_write = act && (slot_cmd == CMD_WRITE);
  wire           do_flush = act && (slot_cmd == CMD_FLUSH);
  wire           row_end  = (col == width_q - 1'b1);
  wire [PW-1:0]  step     = desc_q ? {PW{1'b1}} : PW'(1);
  wire [PW-1:0]  mod_in   = cfg_dst_en ? (cfg_desc ? (~cfg_modulo + PW'(1)) : cfg_modulo) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy         <= 1'b0;
      phase_full   <= 1'b0;
      ptr          <= '0;
      held_addr    <= '0;
      held_word    <= '0;
      col          <= '0;
      width_q      <= '0;
      desc_q       <= 1'b0;
      row_adj      <= '0;
      rows_left    <= '0;
      mem_we       <= 1'b0;
      mem_addr     <= '0;
      mem_wdata    <= '0;
      done_irq     <= 1'b0;
      seq_complete <= 1'b0;
    end else begin
      mem_we       <= 1'b0;
      done_irq     <= 1'b0;
      seq_complete <= 1'b0;
      if (start) begin
        busy       <= 1'b1;
        phase_full <= 1'b0;
        ptr        <= cfg_base;
        col        <= '0;
        width_q    <= cfg_width;
        desc_q     <= cfg_desc;
        row_adj    <= mod_in;
        rows_left  <= cfg_height;
      end else if (do_write || do_flush) begin
        if (phase_full) begin
          mem_we    <= 1'b1;
          mem_addr  <= held_addr & RAM_MASK;
          mem_wdata <= held_word;
        end
        if (do_write) begin
          phase_full <= 1'b1;
          held_addr  <= ptr;
          held_word  <= out_word;
          if (row_end) begin
            col <= '0;
            ptr <= ptr + step + row_adj;
            if (rows_left != '0) begin
              rows_left <= rows_left - 1'b1;
              if (rows_left == HW'(1)) seq_complete <= 1'b1;
            end
          end else begin
            col <= col + 1'b1;
            ptr <= ptr + step;
          end
        end else begin
          phase_full <= 1'b0;
          busy       <= 1'b0;
          rows_left  <= '0;
          done_irq   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/blit_wb_stage_chk.sv
module blit_wb_stage_chk #(
  parameter int PW     = 24,
  parameter int RAM_AW = 16,
  parameter int HW     = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [1:0]    slot_cmd,
  input logic          busy,
  input logic          phase_full,
  input logic [PW-1:0] ptr,
  input logic          mem_we,
  input logic [PW-1:0] mem_addr,
  input logic          done_irq,
  input logic [HW-1:0] rows_left
);
  localparam logic [PW-1:0] MASK = PW'((65'd1 << RAM_AW) - 65'd1);

  // R11
  wr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(busy && !start && phase_full && (slot_cmd == 2'd1 || slot_cmd == 2'd2)));

  // R10
  addr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ((mem_addr & ~MASK) == '0));

  // R8
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> $past(busy && !start && slot_cmd == 2'd2));

  // R8
  irq_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> (!busy && rows_left == '0));

  // R9
  idle_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy && !start && (slot_cmd == 2'd0 || slot_cmd == 2'd3))
      |-> ($stable(ptr) && $stable(phase_full) && !mem_we));

  // R2
  first_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start) |-> (!phase_full && !mem_we && busy));

  // R12
  idle_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!busy && !start) |-> (!mem_we && !done_irq && $stable(ptr)));
endmodule

bind blit_wb_stage blit_wb_stage_chk #(.PW(PW), .RAM_AW(RAM_AW), .HW(HW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .slot_cmd(slot_cmd), .busy(busy),
  .phase_full(phase_full), .ptr(ptr), .mem_we(mem_we), .mem_addr(mem_addr),
  .done_irq(done_irq), .rows_left(rows_left)
);

// File: tb/tb_blit_wb_stage.sv
module tb_blit_wb_stage;
  localparam int PW = 24, RAM_AW = 16, CW = 8, HW = 10, DW = 16;
  localparam logic [PW-1:0] MASK = PW'((65'd1 << RAM_AW) - 65'd1);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [PW-1:0] cfg_base = '0, cfg_modulo = '0;
  logic cfg_desc = 1'b0, cfg_dst_en = 1'b0;
  logic [CW-1:0] cfg_width = '0;
  logic [HW-1:0] cfg_height = '0;
  logic [1:0] slot_cmd = 2'd0;
  logic [DW-1:0] out_word = '0;
  logic mem_we, seq_complete, done_irq, busy;
  logic [PW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [HW-1:0] rows_left;

  always #2 clk = ~clk;

  blit_wb_stage #(.PW(PW), .RAM_AW(RAM_AW), .CW(CW), .HW(HW), .DW(DW)) dut (.*);

  int checks = 0, failures = 0;
  logic [PW+DW-1:0] exp_q[$];
  int seq_seen = 0, irq_seen = 0;

  // bench-side expectation state
  bit m_busy = 0, m_full = 0, m_desc = 0;
  logic [PW-1:0] m_ptr, m_haddr, m_adj;
  logic [DW-1:0] m_hword;
  int m_col, m_w, m_rows, m_seq_exp = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compare each memory write with the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (seq_complete) seq_seen++;
      if (done_irq) irq_seen++;
      if (mem_we) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R12/R9 unexpected write", {mem_addr, mem_wdata}, 0);
        end else begin
          logic [PW+DW-1:0] e;
          e = exp_q.pop_front();
          check({mem_addr, mem_wdata} == e, "R3/R4/R5/R10 write", {mem_addr, mem_wdata}, e);
        end
      end
    end
  end

  task automatic begin_op(input logic [PW-1:0] base, input logic [PW-1:0] modu, input bit desc,
                          input bit en, input int w, input int h);
    cfg_base = base; cfg_modulo = modu; cfg_desc = desc; cfg_dst_en = en;
    cfg_width = CW'(w); cfg_height = HW'(h);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    m_busy = 1; m_full = 0; m_ptr = base; m_col = 0; m_w = w; m_rows = h; m_desc = desc;
    m_adj = en ? (desc ? (~modu + PW'(1)) : modu) : '0;
  endtask

  task automatic slot(input logic [1:0] cmd, input logic [DW-1:0] word);
    slot_cmd = cmd; out_word = word;
    if (m_busy && (cmd == 2'd1 || cmd == 2'd2)) begin
      if (m_full) exp_q.push_back({m_haddr & MASK, m_hword});
      if (cmd == 2'd1) begin
        m_full = 1; m_haddr = m_ptr; m_hword = word;
        m_ptr = m_ptr + (m_desc ? {PW{1'b1}} : PW'(1));
        m_col++;
        if (m_col == m_w) begin
          m_col = 0; m_ptr = m_ptr + m_adj;
          if (m_rows > 0) begin
            m_rows--;
            if (m_rows == 0) m_seq_exp++;
          end
        end
      end else begin
        m_full = 0; m_busy = 0; m_rows = 0;
      end
    end
    @(posedge clk); #1;
    slot_cmd = 2'd0;
  endtask

  task automatic end_checks(input string tag, input int irq_exp);
    @(posedge clk); #1;
    check(exp_q.size() == 0, {tag, " R7 pending writes"}, exp_q.size(), 0);
    check(!busy, {tag, " R8 busy"}, busy, 0);
    check(rows_left == 0, {tag, " R8 rows_left"}, rows_left, 0);
    check(irq_seen == irq_exp, {tag, " R8 irq count"}, irq_seen, irq_exp);
    check(seq_seen == m_seq_exp, {tag, " R6 seq_complete count"}, seq_seen, m_seq_exp);
  endtask

  initial begin
    #400;
    check(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1
    check(!mem_we && !done_irq && !busy && !seq_complete && rows_left == 0, "R1 in reset",
          {mem_we, done_irq, busy, seq_complete}, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(!mem_we && !busy && rows_left == 0, "R1 after reset", {mem_we, busy}, 0);

    // R12: commands while idle
    slot(2'd1, 16'hdead); slot(2'd2, 16'hbeef); slot(2'd1, 16'h1111);
    check(!busy && !done_irq, "R12 idle cmds", {busy, done_irq}, 0);

    // Op A: ascending, 3x2, modulo 5, with none/read slots between writes
    begin_op(24'h000100, 24'd5, 0, 1, 3, 2);
    check(busy && rows_left == 2, "R2 start loads", rows_left, 2);
    slot(2'd1, 16'ha001);
    check(!mem_we, "R2 first write held", mem_we, 0);
    slot(2'd0, 16'h0); slot(2'd3, 16'h0);
    slot(2'd1, 16'ha002); slot(2'd1, 16'ha003);
    check(rows_left == 1, "R6 row end", rows_left, 1);
    slot(2'd3, 16'h0);
    slot(2'd1, 16'ha004); slot(2'd0, 16'h0); slot(2'd1, 16'ha005); slot(2'd1, 16'ha006);
    check(seq_complete && rows_left == 0, "R6 last row pulse", {seq_complete, rows_left}, 2'b10);
    slot(2'd2, 16'h0);
    check(done_irq, "R8 irq pulse", done_irq, 1);
    @(posedge clk); #1;
    check(!done_irq, "R8 irq one cycle", done_irq, 0);
    end_checks("opA", 1);

    // Op B: descending, masked addresses, back-to-back writes
    begin_op(24'h120001, 24'd2, 1, 1, 2, 3);
    for (int i = 0; i < 6; i++) slot(2'd1, 16'hb000 + 16'(i));
    slot(2'd2, 16'h0);
    end_checks("opB R4/R10/R11", 2);

    // Op C: channel disabled, modulo must not apply
    begin_op(24'h000200, 24'd40, 0, 0, 2, 2);
    for (int i = 0; i < 4; i++) slot(2'd1, 16'hc000 + 16'(i));
    slot(2'd2, 16'h0);
    end_checks("opC R5", 3);

    // Op D: flush straight after start, holding register empty
    begin_op(24'h000300, 24'd0, 0, 1, 4, 5);
    slot(2'd2, 16'h0);
    check(!mem_we && done_irq, "R7 empty flush", {mem_we, done_irq}, 2'b01);
    end_checks("opD R7", 4);

    // Op E: early flush forces rows_left to zero
    begin_op(24'h000400, 24'd1, 0, 1, 2, 6);
    for (int i = 0; i < 3; i++) slot(2'd1, 16'he000 + 16'(i));
    check(rows_left == 5, "R6 partial", rows_left, 5);
    slot(2'd2, 16'h0);
    end_checks("opE R8", 5);

    // R12: idle commands after the operation
    slot(2'd1, 16'h7777); slot(2'd2, 16'h0);
    @(posedge clk); #1;
    check(irq_seen == 5 && exp_q.size() == 0, "R12 post-op idle", irq_seen, 5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule